// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block produces the digital switch controls for a multiplexed segment LCD driver. A prescaled LCD clock arrives as a one-cycle `lcd_tick` pulse. On each tick the sequencer addresses the next common line, starting from common 0, until it has covered the number of commons set by `duty`. It then wraps and begins a new frame. For every common pin and every segment pin it registers a 2-bit voltage-level code and an output enable. The analog switch array and the level generators outside the block act on these signals.

Software writes one row of segment bits per common into a register bank. At the first tick of each frame the whole bank is copied into a holding copy, so the displayed frame always comes from one consistent snapshot. The waveform polarity flips at every frame boundary, which keeps the net DC across each segment at zero. In multiplexed modes the intermediate-level buffers and the pin drivers are enabled only for a programmed drive window after each tick. The pins are then tri-stated for the rest of the LCD clock period. No pin is enabled while the LCD supply is not ready.

Top module: `lcd_waveform_seq`

## Requirements
- R1: `duty` value d selects d+1 commons. On each tick the addressed common advances 0,1,...,d and then wraps to 0. `frame_start` is high for exactly the one cycle after each tick that addresses common 0. The first tick after reset addresses common 0.
- R2: Bank row c holds the segment bits for common c, with bit s meaning segment s is on. Rows are copied at the frame-start tick. A write made after that tick does not show until the next frame's start.
- R3: Level codes are 00 = ground, 11 = full supply, 01 = low intermediate, 10 = high intermediate. In a multiplexed mode the addressed common gets 00 in phase 0 and 11 in phase 1. A non-addressed common gets 01 at half bias. At third bias it gets 10 in phase 0 and 01 in phase 1. `com_lvl[2c+1:2c]` belongs to common c.
- R4: An on segment gets 11 in phase 0 and 00 in phase 1. In a multiplexed mode an off segment gets 01 at half bias. At third bias it gets 01 in phase 0 and 10 in phase 1. `seg_lvl[2s+1:2s]` belongs to segment s.
- R5: The first frame after reset uses phase 0. The phase inverts at every frame start.
- R6: In a multiplexed mode with supply ready, `buf_en` and the enables of the used pins are high for (`drive_sel`+1)*DT_UNIT cycles after each tick. All pin enables are then low until the next tick. Commons above `duty` are never enabled.
- R7: The drive window is capped at half the number of cycles between the two most recent ticks, rounded down.
- R8: In static mode (`duty`=0) every common uses the common-0 waveform (00 in phase 0, 11 in phase 1). On segments get the opposite full level and off segments the same level. `buf_en` stays low, and common 0 and all segments stay enabled for the whole period.
- R9: While `supply_ready` is low, every pin enable and `buf_en` are low.
- R10: After reset all level codes, enables, `buf_en` and `frame_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_tick | input | 1 | One-cycle pulse of the prescaled LCD clock |
| supply_ready | input | 1 | LCD supply has reached its target |
| duty | input | IDX_W | Number of commons minus one |
| bias_third | input | 1 | 1 = third bias, 0 = half bias |
| drive_sel | input | DT_W | Drive window select |
| wr_en | input | 1 | Bank row write strobe |
| wr_com | input | IDX_W | Bank row (common) being written |
| wr_data | input | NUM_SEG | Segment bits for that row |
| com_lvl | output | 2*NUM_COM | Level code per common |
| com_oe | output | NUM_COM | Drive enable per common |
| seg_lvl | output | 2*NUM_SEG | Level code per segment |
| seg_oe | output | NUM_SEG | Drive enable per segment |
| buf_en | output | 1 | Intermediate-level buffer enable |
| frame_start | output | 1 | Pulse marking each frame latch point |

## Verification
The hardest case to reach from the ports is a bank write that lands in the middle of a frame, after the latch. It must stay invisible until the next wrap. The bench writes a row for a common that has not yet been addressed in the current frame, between two ticks. The scoreboard model updates only its bank copy and snapshots it at its own frame start, so any early leak shows as a level mismatch. The window cap is reached by selecting a drive time longer than half the tick spacing. The bench then counts `buf_en` cycles across the whole period.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [1:0] {
    LV_GND  = 2'b00,
    LV_LOW  = 2'b01,
    LV_HIGH = 2'b10,
    LV_VLCD = 2'b11
  } lvl_e;

  // full level that follows the addressed common in a given phase
  function automatic lvl_e full_lvl(input logic phase);
    return phase ? LV_VLCD : LV_GND;
  endfunction

  function automatic lvl_e com_level(input logic addressed, input logic phase,
                                     input logic multi, input logic third);
    if (addressed || !multi) return full_lvl(phase);
    if (!third) return LV_LOW;
    return phase ? LV_LOW : LV_HIGH;
  endfunction

  function automatic lvl_e seg_level(input logic on, input logic phase,
                                     input logic multi, input logic third);
    if (on) return full_lvl(!phase);
    if (!multi) return full_lvl(phase);
    if (!third) return LV_LOW;
    return phase ? LV_HIGH : LV_LOW;
  endfunction
endpackage

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl #(
  parameter int NUM_COM = 4,
  parameter int DT_W    = 3,
  parameter int DT_UNIT = 4,
  parameter int PER_W   = 16,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             multi,
  input  logic [IDX_W-1:0] duty,
  input  logic [DT_W-1:0]  drive_sel,
  output logic [IDX_W-1:0] nxt_idx,
  output logic             nxt_phase,
  output logic             frame_pulse,
  output logic             drive_nxt
);
  logic [IDX_W-1:0] idx_q;
  logic             started_q;
  logic             phase_q;
  logic [PER_W-1:0] per_cnt_q, win_q, win_nxt, req_len, cap_len, len;
  logic [PER_W:0]   interval;

  always_comb begin
    nxt_idx     = (!started_q || idx_q >= duty) ? '0 : idx_q + 1'b1;
    frame_pulse = tick && (nxt_idx == '0);
    nxt_phase   = frame_pulse ? !phase_q : phase_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      started_q <= 1'b0;
      phase_q   <= 1'b1;
    end else if (tick) begin
      idx_q     <= nxt_idx;
      started_q <= 1'b1;
      phase_q   <= nxt_phase;
    end
  end

  // cycles between ticks, saturating
  always_ff @(posedge clk) begin
    if (rst || tick) per_cnt_q <= '0;
    else if (!(&per_cnt_q)) per_cnt_q <= per_cnt_q + 1'b1;
  end

  always_comb begin
    interval = {1'b0, per_cnt_q} + 1'b1;
    cap_len  = interval[PER_W:1];
    req_len  = (PER_W'(drive_sel) + PER_W'(1)) * PER_W'(DT_UNIT);
    len      = (req_len > cap_len) ? cap_len : req_len;
    if (tick) win_nxt = multi ? len : '0;
    else if (win_q != '0) win_nxt = win_q - 1'b1;
    else win_nxt = '0;
    drive_nxt = (win_nxt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else win_q <= win_nxt;
  end

  // R5
  phase_flip_chk: assert property (@(posedge clk) disable iff (rst)
    frame_pulse |=> (phase_q != $past(phase_q)));

  // R6
  win_step_chk: assert property (@(posedge clk) disable iff (rst)
    (win_q != '0 && !tick) |=> (win_q == $past(win_q) - 1'b1));
endmodule

// File: rtl/lcd_seg_bank.sv
module lcd_seg_bank #(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 8,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_com,
  input  logic [NUM_SEG-1:0] wr_data,
  input  logic               latch,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [NUM_SEG-1:0] row
);
  logic [NUM_COM-1:0][NUM_SEG-1:0] bank_q;
  logic [NUM_COM-1:0][NUM_SEG-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (wr_en) bank_q[wr_com] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= '0;
    else if (latch) hold_q <= bank_q;
  end

  // the row used at the latching tick comes straight from the bank
  assign row = latch ? bank_q[rd_idx] : hold_q[rd_idx];

  // R2
  hold_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(hold_q));
endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
  import lcd_seq_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 8,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic [IDX_W-1:0]     idx,
  input  logic                 phase,
  input  logic                 multi,
  input  logic                 third,
  input  logic [NUM_SEG-1:0]   row,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl
);
  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    assign com_lvl[2*c +: 2] = com_level(idx == IDX_W'(c), phase, multi, third);
  end

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    assign seg_lvl[2*s +: 2] = seg_level(row[s], phase, multi, third);
  end
endmodule

// File: rtl/lcd_waveform_seq.sv
module lcd_waveform_seq #(
  parameter int NUM_COM = 4,
  parameter int NUM_SEG = 8,
  parameter int DT_W    = 3,
  parameter int DT_UNIT = 4,
  parameter int PER_W   = 16,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 lcd_tick,
  input  logic                 supply_ready,
  input  logic [IDX_W-1:0]     duty,
  input  logic                 bias_third,
  input  logic [DT_W-1:0]      drive_sel,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_com,
  input  logic [NUM_SEG-1:0]   wr_data,
  output logic [2*NUM_COM-1:0] com_lvl,
  output logic [NUM_COM-1:0]   com_oe,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [NUM_SEG-1:0]   seg_oe,
  output logic                 buf_en,
  output logic                 frame_start
);
  logic                 multi;
  logic [IDX_W-1:0]     nxt_idx;
  logic                 nxt_phase, frame_pulse, drive_nxt;
  logic [NUM_SEG-1:0]   row;
  logic [2*NUM_COM-1:0] map_com;
  logic [2*NUM_SEG-1:0] map_seg;
  logic                 pin_on;

  assign multi  = (duty != '0);
  assign pin_on = supply_ready && (!multi || drive_nxt);

  lcd_frame_ctrl #(.NUM_COM(NUM_COM), .DT_W(DT_W), .DT_UNIT(DT_UNIT), .PER_W(PER_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(lcd_tick), .multi(multi), .duty(duty),
    .drive_sel(drive_sel), .nxt_idx(nxt_idx), .nxt_phase(nxt_phase),
    .frame_pulse(frame_pulse), .drive_nxt(drive_nxt)
  );

  lcd_seg_bank #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_com(wr_com), .wr_data(wr_data),
    .latch(frame_pulse), .rd_idx(nxt_idx), .row(row)
  );

  lcd_level_map #(.NUM_COM(NUM_COM), .NUM_SEG(NUM_SEG)) u_map (
    .idx(nxt_idx), .phase(nxt_phase), .multi(multi), .third(bias_third),
    .row(row), .com_lvl(map_com), .seg_lvl(map_seg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      com_lvl     <= '0;
      seg_lvl     <= '0;
      frame_start <= 1'b0;
      buf_en      <= 1'b0;
      seg_oe      <= '0;
    end else begin
      if (lcd_tick) begin
        com_lvl <= map_com;
        seg_lvl <= map_seg;
      end
      frame_start <= frame_pulse;
      buf_en      <= supply_ready && drive_nxt;
      seg_oe      <= {NUM_SEG{pin_on}};
    end
  end

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com_oe
    always_ff @(posedge clk) begin
      if (rst) com_oe[c] <= 1'b0;
      else com_oe[c] <= pin_on && (IDX_W'(c) <= duty);
    end
  end

  // R9
  inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    !supply_ready |=> (com_oe == '0 && seg_oe == '0 && !buf_en));

  // R8
  static_nobuf_chk: assert property (@(posedge clk) disable iff (rst)
    (lcd_tick && duty == '0) |=> !buf_en);
endmodule

// File: tb/lcd_waveform_seq_test.sv
module lcd_waveform_seq_test;
  localparam int NC = 4, NS = 8, UNIT = 4;

  logic clk = 1'b0, rst = 1'b1, lcd_tick = 1'b0, supply_ready = 1'b0;
  logic [1:0] duty = '0, wr_com = '0;
  logic bias_third = 1'b0, wr_en = 1'b0;
  logic [2:0] drive_sel = '0;
  logic [NS-1:0] wr_data = '0;
  logic [2*NC-1:0] com_lvl;
  logic [NC-1:0] com_oe;
  logic [2*NS-1:0] seg_lvl;
  logic [NS-1:0] seg_oe;
  logic buf_en, frame_start;

  lcd_waveform_seq uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [2*NC+2*NS:0] exp_q[$];

  logic [NS-1:0] bank_m[NC], hold_m[NC];
  int idx_m = 0, prev_per = 0;
  bit started_m = 0, phase_m = 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] e_com(bit addr, bit ph, bit multi, bit third);
    if (addr || !multi) return ph ? 2'b11 : 2'b00;
    if (!third) return 2'b01;
    return ph ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] e_seg(bit on, bit ph, bit multi, bit third);
    if (on) return ph ? 2'b00 : 2'b11;
    if (!multi) return ph ? 2'b11 : 2'b00;
    if (!third) return 2'b01;
    return ph ? 2'b10 : 2'b01;
  endfunction

  // monitor: compare registered levels one step after each tick edge
  always @(posedge clk) begin
    if (lcd_tick === 1'b1) begin
      logic [2*NC+2*NS:0] e;
      #1;
      if (exp_q.size() == 0) chk("R1 empty scoreboard", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk("R1 frame_start", 32'(frame_start), 32'(e[2*NC+2*NS]));
        chk("R3 com_lvl", 32'(com_lvl), 32'(e[2*NC+2*NS-1:2*NS]));
        chk("R4 R2 seg_lvl", 32'(seg_lvl), 32'(e[2*NS-1:0]));
      end
    end
  end

  task automatic wr(int c, logic [NS-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_com = 2'(c); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    bank_m[c] = d;
  endtask

  task automatic do_tick(int per);
    bit multi = (duty != 0);
    int nx, len, cnt;
    logic [2*NC-1:0] ec;
    logic [2*NS-1:0] es;
    logic [NC-1:0] oe_c;
    bit fs;
    nx = (!started_m || idx_m >= int'(duty)) ? 0 : idx_m + 1;
    fs = (nx == 0);
    if (fs) begin
      for (int c = 0; c < NC; c++) hold_m[c] = bank_m[c];
      phase_m = !phase_m;
    end
    idx_m = nx; started_m = 1;
    for (int c = 0; c < NC; c++) ec[2*c +: 2] = e_com(c == idx_m, phase_m, multi, bias_third);
    for (int s = 0; s < NS; s++) es[2*s +: 2] = e_seg(hold_m[idx_m][s], phase_m, multi, bias_third);
    exp_q.push_back({fs, ec, es});
    len = (int'(drive_sel) + 1) * UNIT;
    if (prev_per != 0 && len > prev_per / 2) len = prev_per / 2;
    if (!multi) len = 0;
    for (int c = 0; c < NC; c++) oe_c[c] = supply_ready && (c <= int'(duty));
    lcd_tick = 1;
    @(negedge clk);
    lcd_tick = 0;
    cnt = 0;
    for (int i = 0; i < per; i++) begin
      if (buf_en) cnt++;
      if (prev_per != 0 && i == 0) begin
        chk("R6 R9 com_oe in window", 32'(com_oe), 32'(oe_c));
        chk("R6 R9 seg_oe in window", 32'(seg_oe), supply_ready ? 32'({NS{1'b1}}) : 32'd0);
      end
      if (prev_per != 0 && i == per - 1) begin
        chk(multi ? "R6 com_oe after window" : "R8 com_oe static", 32'(com_oe), multi ? 32'd0 : 32'(oe_c));
        chk(multi ? "R6 seg_oe after window" : "R8 seg_oe static", 32'(seg_oe),
            (!multi && supply_ready) ? 32'({NS{1'b1}}) : 32'd0);
      end
      if (i < per - 1) @(negedge clk);
    end
    if (prev_per != 0) begin
      if (!supply_ready) chk("R9 buf_en cycles", cnt, 0);
      else if (!multi) chk("R8 buf_en cycles", cnt, 0);
      else if ((int'(drive_sel) + 1) * UNIT > prev_per / 2) chk("R7 capped window", cnt, len);
      else chk("R6 window length", cnt, len);
    end
    prev_per = per;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R10 reset com_lvl", 32'(com_lvl), 0);
    chk("R10 reset seg_lvl", 32'(seg_lvl), 0);
    chk("R10 reset enables", {com_oe, seg_oe, buf_en, frame_start}, 0);
    for (int c = 0; c < NC; c++) wr(c, NS'(8'h1D + c * 8'h37));
    // R1 R3 R4 R5: four commons, third bias
    supply_ready = 1; duty = 3; bias_third = 1; drive_sel = 1;
    do_tick(40); do_tick(40);
    // R2: row 3 rewritten after this frame's latch
    wr(3, 8'hF0);
    do_tick(40); do_tick(40); do_tick(40); do_tick(40);
    // R7: requested window longer than half the period
    drive_sel = 7;
    do_tick(40); do_tick(40); do_tick(40);
    // two commons, half bias
    duty = 1; bias_third = 0; drive_sel = 2;
    wr(0, 8'h81);
    do_tick(40); do_tick(40); do_tick(40); do_tick(40); do_tick(40);
    // three commons, third bias, wider period
    duty = 2; bias_third = 1; drive_sel = 7;
    do_tick(60); do_tick(60); do_tick(60); do_tick(60);
    // R8 static
    duty = 0;
    do_tick(40); do_tick(40); do_tick(40);
    // R9 supply inhibit
    supply_ready = 0; duty = 3;
    do_tick(40); do_tick(40); do_tick(40); do_tick(40);
    repeat (4) @(negedge clk);
    chk("R1 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule